// File: doc/BRIEF.md
# Paired Event Counters with Reload

This block holds two event counters, A and B, that run as a linked pair. Each counter has its own increment strobe. It can be loaded from a preset value, and the condition that triggers the load is set by a two-bit reload mode. The condition can look at the counter itself or at its partner: the counter's own wrap, the partner's wrap, or a cycle in which the partner does not count. A single run enable starts and stops both counters together, so their counts stay aligned in time.

Software configures the pair through a simple write port. That port loads the counts, the presets and the modes, and it clears the sticky wrap flags. Both count values and both flags are always visible on output pins. Event detection and qualification stay outside the block. Each counter sees at most one qualified strobe per cycle. Every interface is plain control and status, so no data-stream handshake is involved.

Top module: `pair_evt_counter`

## Requirements
- R1: After reset both counts, both presets, both modes and both wrap flags are zero.
- R2: A counter adds one only in a cycle where `run_en` and its own strobe are both high. With `run_en` low, the strobes have no effect.
- R3: An increment from the all-ones value yields zero and sets that counter's wrap flag. Flag bit 0 belongs to A and bit 1 to B.
- R4: Mode 0 never loads the preset. A wrap in mode 0 leaves the count at zero.
- R5: Mode 1 loads the counter's own preset in the cycle where it would wrap, and it still sets that counter's wrap flag.
- R6: Mode 2 loads the preset in the same cycle in which the partner wraps from all-ones.
- R7: Mode 3 loads the preset in every cycle where `run_en` is high and the partner's strobe is low. No reload condition acts while `run_en` is low.
- R8: When a reload and an increment coincide, the counter takes the preset and the increment is discarded.
- R9: A software write to a count register beats both reload and increment in that cycle.
- R10: A wrap flag stays set until a clear write. A wrap in the same cycle as a clear leaves the flag set.
- R11: The write map is: address 0 is count A, 1 is count B, 2 is preset A, 3 is preset B, and 4 is the modes, with data bits [1:0] for A and [3:2] for B. Address 5 clears the flags, with data bit 0 for A and bit 1 for B. Writes to addresses 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Shared start/stop for both counters |
| inc_a | input | 1 | Qualified event strobe for counter A |
| inc_b | input | 1 | Qualified event strobe for counter B |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| count_a | output | CNT_W | Current value of counter A |
| count_b | output | CNT_W | Current value of counter B |
| ovf_flag | output | 2 | Sticky wrap flags, bit 0 for A and bit 1 for B |

## Verification
The hardest situations to reach are the coincidences: a partner wrap landing in the same clock as the counter's own strobe, a clear landing on a wrap, and a software write landing on an active reload. With 32-bit counters, a wrap cannot be reached by counting. The stimulus therefore writes a count to all-ones, or one below it, and then fires the strobes together in a single chosen cycle. That makes each collision happen on one known edge, where the scoreboard holds the expected counts and flags.

// File: rtl/pec_pkg.sv
package pec_pkg;
  typedef enum logic [1:0] {
    RL_NEVER     = 2'd0,
    RL_SELF_WRAP = 2'd1,
    RL_PEER_WRAP = 2'd2,
    RL_PEER_IDLE = 2'd3
  } rl_mode_e;

  localparam int ADDR_W = 3;
  localparam int N_CNT  = 2;

  localparam logic [ADDR_W-1:0] A_CNT_A = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_B = 3'd1;
  localparam logic [ADDR_W-1:0] A_PRE_A = 3'd2;
  localparam logic [ADDR_W-1:0] A_PRE_B = 3'd3;
  localparam logic [ADDR_W-1:0] A_MODE  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CLR   = 3'd5;

  typedef struct packed {
    logic sw_load;
    logic reload;
    logic step;
    logic flag_set;
  } cnt_ctl_t;
endpackage

// File: rtl/pec_regs.sv
module pec_regs
  import pec_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [CNT_W-1:0]            wr_data,
  output logic [N_CNT-1:0][CNT_W-1:0] preset_o,
  output logic [N_CNT-1:0][1:0]       mode_o,
  output logic [N_CNT-1:0]            cnt_wr_o,
  output logic [N_CNT-1:0]            flag_clr_o
);
  localparam logic [ADDR_W-1:0] CNT_BASE = A_CNT_A;
  localparam logic [ADDR_W-1:0] PRE_BASE = A_PRE_A;

  logic mode_hit, clr_hit;
  assign mode_hit = wr_en && (wr_addr == A_MODE);
  assign clr_hit  = wr_en && (wr_addr == A_CLR);

  for (genvar i = 0; i < N_CNT; i++) begin : g_slot
    logic pre_hit;
    assign pre_hit       = wr_en && (wr_addr == PRE_BASE + ADDR_W'(i));
    assign cnt_wr_o[i]   = wr_en && (wr_addr == CNT_BASE + ADDR_W'(i));
    assign flag_clr_o[i] = clr_hit && wr_data[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        preset_o[i] <= '0;
        mode_o[i]   <= RL_NEVER;
      end else begin
        if (pre_hit)  preset_o[i] <= wr_data;
        if (mode_hit) mode_o[i]   <= wr_data[2*i +: 2];
      end
    end
  end
endmodule

// File: rtl/pec_reload_ctl.sv
module pec_reload_ctl
  import pec_pkg::*;
(
  input  logic                  run_en,
  input  logic [N_CNT-1:0]      inc,
  input  logic [N_CNT-1:0]      at_max,
  input  logic [N_CNT-1:0]      cnt_wr,
  input  logic [N_CNT-1:0][1:0] mode,
  output cnt_ctl_t [N_CNT-1:0]  ctl
);
  logic [N_CNT-1:0] raw_wrap;

  for (genvar i = 0; i < N_CNT; i++) begin : g_raw
    assign raw_wrap[i] = run_en && inc[i] && at_max[i] && !cnt_wr[i];
  end

  for (genvar i = 0; i < N_CNT; i++) begin : g_ctl
    localparam int PEER = N_CNT - 1 - i;
    logic     cond;
    logic     rl;
    rl_mode_e m;

    assign m = rl_mode_e'(mode[i]);

    always_comb begin
      unique case (m)
        RL_NEVER:     cond = 1'b0;
        RL_SELF_WRAP: cond = raw_wrap[i];
        RL_PEER_WRAP: cond = raw_wrap[PEER];
        RL_PEER_IDLE: cond = !inc[PEER];
        default:      cond = 1'b0;
      endcase
    end

    assign rl                 = cond && run_en && !cnt_wr[i];
    assign ctl[i].sw_load     = cnt_wr[i];
    assign ctl[i].reload      = rl;
    assign ctl[i].step        = run_en && inc[i] && !rl && !cnt_wr[i];
    assign ctl[i].flag_set    = raw_wrap[i] && (!rl || (m == RL_SELF_WRAP));
  end
endmodule

// File: rtl/pec_counter.sv
module pec_counter
  import pec_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_ctl_t         ctl,
  input  logic [CNT_W-1:0] sw_value,
  input  logic [CNT_W-1:0] preset,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             at_max,
  output logic             flag
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  assign at_max = &count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (ctl.sw_load) begin
      count <= sw_value;
    end else if (ctl.reload) begin
      count <= preset;
    end else if (ctl.step) begin
      count <= count + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             flag <= 1'b0;
    else if (ctl.flag_set)  flag <= 1'b1;
    else if (flag_clr)      flag <= 1'b0;
  end
endmodule

// File: rtl/pair_evt_counter.sv
module pair_evt_counter
  import pec_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             inc_a,
  input  logic             inc_b,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count_a,
  output logic [CNT_W-1:0] count_b,
  output logic [1:0]       ovf_flag
);
  logic [N_CNT-1:0][CNT_W-1:0] preset_w;
  logic [N_CNT-1:0][CNT_W-1:0] count_w;
  logic [N_CNT-1:0][1:0]       mode_w;
  logic [N_CNT-1:0]            cnt_wr_w;
  logic [N_CNT-1:0]            flag_clr_w;
  logic [N_CNT-1:0]            at_max_w;
  logic [N_CNT-1:0]            flag_w;
  cnt_ctl_t [N_CNT-1:0]        ctl_w;

  pec_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .preset_o   (preset_w),
    .mode_o     (mode_w),
    .cnt_wr_o   (cnt_wr_w),
    .flag_clr_o (flag_clr_w)
  );

  pec_reload_ctl u_ctl (
    .run_en (run_en),
    .inc    ({inc_b, inc_a}),
    .at_max (at_max_w),
    .cnt_wr (cnt_wr_w),
    .mode   (mode_w),
    .ctl    (ctl_w)
  );

  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    pec_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl      (ctl_w[i]),
      .sw_value (wr_data),
      .preset   (preset_w[i]),
      .flag_clr (flag_clr_w[i]),
      .count    (count_w[i]),
      .at_max   (at_max_w[i]),
      .flag     (flag_w[i])
    );
  end

  assign count_a  = count_w[0];
  assign count_b  = count_w[1];
  assign ovf_flag = flag_w;
endmodule

// File: rtl/pec_checks.sv
module pec_checks
  import pec_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        run_en,
  input logic                        inc_a,
  input logic                        inc_b,
  input logic                        wr_en,
  input logic [2:0]                  wr_addr,
  input logic [CNT_W-1:0]            count_a,
  input logic [CNT_W-1:0]            count_b,
  input logic [1:0]                  ovf_flag,
  input logic [N_CNT-1:0][1:0]       mode_w,
  input logic [N_CNT-1:0][CNT_W-1:0] preset_w
);
  logic wr_a, wr_b, wr_clr;
  assign wr_a   = wr_en && (wr_addr == A_CNT_A);
  assign wr_b   = wr_en && (wr_addr == A_CNT_B);
  assign wr_clr = wr_en && (wr_addr == A_CLR);

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !wr_en) |=> ($stable(count_a) && $stable(count_b)));

  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && inc_a && (&count_a) && mode_w[0] == 2'd0 && !wr_a)
      |=> (count_a == '0 && ovf_flag[0]));

  p_self_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && inc_a && (&count_a) && mode_w[0] == 2'd1 && !wr_a)
      |=> (count_a == $past(preset_w[0]) && ovf_flag[0]));

  p_peer_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && inc_a && (&count_a) && !wr_a && mode_w[1] == 2'd2 && !wr_b)
      |=> (count_b == $past(preset_w[1])));

  p_peer_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !inc_b && mode_w[0] == 2'd3 && !wr_a)
      |=> (count_a == $past(preset_w[0])));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag[0] && !wr_clr) |=> ovf_flag[0]);
endmodule

bind pair_evt_counter pec_checks #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_en   (run_en),
  .inc_a    (inc_a),
  .inc_b    (inc_b),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .count_a  (count_a),
  .count_b  (count_b),
  .ovf_flag (ovf_flag),
  .mode_w   (mode_w),
  .preset_w (preset_w)
);

// File: tb/pair_evt_counter_bench.sv
`timescale 1ns/1ps
module pair_evt_counter_bench;
  localparam int CNT_W = 32;
  localparam logic [CNT_W-1:0] MX = '1;

  typedef struct {
    logic [CNT_W-1:0] ea;
    logic [CNT_W-1:0] eb;
    logic [1:0]       ef;
    string            tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n, run_en, inc_a, inc_b, wr_en;
  logic [2:0] wr_addr;
  logic [CNT_W-1:0] wr_data, count_a, count_b;
  logic [1:0] ovf_flag;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;
  exp_t sb[$];

  always #4 clk = ~clk;

  pair_evt_counter #(.CNT_W(CNT_W)) u_pair_evt_counter (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .inc_a(inc_a), .inc_b(inc_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count_a(count_a), .count_b(count_b), .ovf_flag(ovf_flag)
  );

  task automatic drv(input logic en, input logic ia, input logic ib,
                     input logic we, input logic [2:0] ad, input logic [CNT_W-1:0] dt,
                     input logic [CNT_W-1:0] ea, input logic [CNT_W-1:0] eb,
                     input logic [1:0] ef, input string tag);
    exp_t e;
    run_en = en; inc_a = ia; inc_b = ib;
    wr_en = we; wr_addr = ad; wr_data = dt;
    e.ea = ea; e.eb = eb; e.ef = ef; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    run_en = 0; inc_a = 0; inc_b = 0; wr_en = 0;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        tests++;
        if (count_a !== e.ea || count_b !== e.eb || ovf_flag !== e.ef) begin
          fails++;
          $display("FAIL %s: got a=%h b=%h f=%b expected a=%h b=%h f=%b",
                   e.tag, count_a, count_b, ovf_flag, e.ea, e.eb, e.ef);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 0; run_en = 0; inc_a = 0; inc_b = 0; wr_en = 0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tests++;
    if (count_a !== '0 || count_b !== '0 || ovf_flag !== 2'b00) begin
      fails++;
      $display("FAIL R1 reset: got a=%h b=%h f=%b expected zeros", count_a, count_b, ovf_flag);
    end
    // R1/R2 strobes without enable are ignored
    drv(0,1,1, 0,3'd0,'0,      0,   0, 2'b00, "R2 disabled strobes");
    drv(1,1,0, 0,3'd0,'0,      1,   0, 2'b00, "R2 count a");
    drv(1,1,1, 0,3'd0,'0,      2,   1, 2'b00, "R2 count both");
    // R11 map writes
    drv(0,0,0, 1,3'd2,32'd5,   2,   1, 2'b00, "R11 preset a");
    drv(0,0,0, 1,3'd0,MX-1,    MX-1,1, 2'b00, "R11 count a write");
    drv(1,1,0, 0,3'd0,'0,      MX,  1, 2'b00, "R2 reach max");
    drv(1,1,0, 0,3'd0,'0,      0,   1, 2'b01, "R3 R4 wrap in mode 0");
    drv(0,0,0, 0,3'd0,'0,      0,   1, 2'b01, "R10 flag sticky");
    drv(0,0,0, 1,3'd5,32'd1,   0,   1, 2'b00, "R10 clear flag a");
    // R5 self reload
    drv(0,0,0, 1,3'd4,32'd1,   0,   1, 2'b00, "R11 mode write");
    drv(0,0,0, 1,3'd0,MX,      MX,  1, 2'b00, "R11 count a max");
    drv(1,1,0, 0,3'd0,'0,      5,   1, 2'b01, "R5 self reload");
    drv(0,0,0, 1,3'd0,MX,      MX,  1, 2'b01, "R9 count write");
    drv(1,1,0, 1,3'd5,32'd1,   5,   1, 2'b01, "R10 wrap beats clear");
    drv(0,0,0, 1,3'd5,32'd3,   5,   1, 2'b00, "R10 clear both");
    // R6 peer wrap, B in mode 2
    drv(0,0,0, 1,3'd4,32'd8,   5,   1, 2'b00, "R11 mode b=2");
    drv(0,0,0, 1,3'd3,32'd100, 5,   1, 2'b00, "R11 preset b");
    drv(0,0,0, 1,3'd0,MX,      MX,  1, 2'b00, "R11 count a max");
    drv(0,0,0, 1,3'd1,32'd7,   MX,  7, 2'b00, "R11 count b write");
    drv(1,1,1, 0,3'd0,'0,      0, 100, 2'b01, "R6 R8 peer wrap reload");
    drv(1,0,1, 0,3'd0,'0,      0, 101, 2'b01, "R6 no peer wrap");
    // R7 peer idle, A in mode 3
    drv(0,0,0, 1,3'd4,32'd3,   0, 101, 2'b01, "R11 mode a=3");
    drv(1,1,0, 0,3'd0,'0,      5, 101, 2'b01, "R7 R8 peer idle reload");
    drv(1,1,1, 0,3'd0,'0,      6, 102, 2'b01, "R7 peer active");
    drv(0,0,0, 0,3'd0,'0,      6, 102, 2'b01, "R7 no reload when disabled");
    // R9 write priority
    drv(1,1,0, 1,3'd0,32'd77,  77,102, 2'b01, "R9 write beats reload");
    drv(1,1,1, 1,3'd1,32'd200, 78,200, 2'b01, "R9 write beats increment");
    drv(0,0,0, 1,3'd6,32'h55,  78,200, 2'b01, "R11 unused address ignored");
    drv(0,0,0, 1,3'd7,32'hF,   78,200, 2'b01, "R11 unused address 7 ignored");
    wait (sb.size() == 0);
    @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule